// File: doc/BRIEF.md
# Sliding-Window Space-Time Trigger Summer

This block makes a level-0 trigger decision from a 14 x 8 grid of digitized analogue-sum channels. Each channel already carries the energy of a 2x2 crystal group. On every bunch clock it removes a programmable pedestal from each channel and forms the sum of every overlapping 2x2 group of channels. Each of these 91 spatial sums is then kept as a running total over the five most recent bunches. Every one of those space-time sums is compared with a single shared threshold, and the results are ORed into one trigger bit.

When the trigger fires and the readout buffer is empty, the block freezes all 91 space-time sums in that buffer. A host then drains it word by word over a simple address/data register bus. That bus also holds the per-channel pedestals, the threshold and the enable bit. The pipeline has a fixed depth, so the trigger lands a known number of bunch clocks after its samples, well inside a twelve-clock budget.

Top module: `l0_window_trigger`

## Requirements
- R1: Each channel value is corrected as raw minus pedestal, clamped at zero when the pedestal is not smaller than the raw value. The 12-bit pedestal of channel row*14+col is written and read at register address row*14+col (0x00 to 0x6F).
- R2: Window (r,c), with r in 0..6 and c in 0..12, sums the corrected channels (r,c), (r,c+1), (r+1,c) and (r+1,c+1). Its window index is r*13+c.
- R3: Each window's space-time sum is the total of its five most recent window sums, computed without overflow.
- R4: The trigger asserts when any space-time sum is strictly greater than the 17-bit threshold at address 0x70. A sum equal to the threshold does not fire.
- R5: A sample set taken at clock edge j can first affect l0_o after edge j+3 and last affects it after edge j+7. The first two edges after rst_n rises are spent by the reset synchronizer.
- R6: l0_o stays low until five complete sample sets have entered the running sums after reset. The earliest point it can rise is after the eighth data edge.
- R7: Bit 0 of address 0x71 is the trigger enable. While it is clear, l0_o is low.
- R8: When l0_o is about to assert and the buffer is empty, all 91 space-time sums that were compared are captured, and the full flag (bit 0 of address 0x72) sets.
- R9: While the buffer is full, new triggers still drive l0_o high but do not overwrite the buffer.
- R10: Each read of address 0x73 while the buffer is full returns the next stored sum in window-index order, starting at 0. Reading index 90 clears the full flag and rewinds the pointer.
- R11: After reset, l0_o is low, the pedestals, threshold, enable and full flag are all zero, and a read of 0x73 while the buffer is empty returns 0. Read data appears on reg_rdata_o one clock after the read strobe, and an undecoded address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_i | input | 1344 | 112 unsigned 12-bit samples; channel row*14+col at bits [ch*12 +: 12] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 17 | Register write data |
| reg_rdata_o | output | 17 | Register read data, valid one clock after the read strobe |
| l0_o | output | 1 | Level-0 trigger decision |

## Verification
The internal state shows up at l0_o and on the readout port within a few clocks. A wrong pedestal clamp, a misplaced window or a running sum that drops or keeps a term makes l0_o differ from an independently computed trigger within three to seven clocks of the sample that causes it. A broken fill counter shows up right after reset as an early trigger. A broken capture guard or pointer shows up in the values read back from 0x73, which are compared against the sums of the trigger that first filled the buffer.

// File: rtl/l0wt_pkg.sv
`timescale 1ns/1ps
package l0wt_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] ADR_THRESH  = 8'h70;
  localparam logic [REG_AW-1:0] ADR_CTRL    = 8'h71;
  localparam logic [REG_AW-1:0] ADR_STATUS  = 8'h72;
  localparam logic [REG_AW-1:0] ADR_READOUT = 8'h73;

  // Width needed to add 'terms' values of 'base_w' bits without overflow.
  function automatic int unsigned sum_width(input int unsigned base_w, input int unsigned terms);
    return base_w + $clog2(terms);
  endfunction
endpackage

// File: rtl/l0wt_ped_sub.sv
`timescale 1ns/1ps
module l0wt_ped_sub #(
  parameter int unsigned NCH   = 112,
  parameter int unsigned SMP_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*SMP_W-1:0] raw_i,
  input  logic [NCH*SMP_W-1:0] ped_i,
  output logic [NCH*SMP_W-1:0] corr_o
);
  logic [NCH*SMP_W-1:0] corr_d, corr_q;

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      if (raw_i[ch*SMP_W +: SMP_W] > ped_i[ch*SMP_W +: SMP_W])
        corr_d[ch*SMP_W +: SMP_W] = raw_i[ch*SMP_W +: SMP_W] - ped_i[ch*SMP_W +: SMP_W];
      else
        corr_d[ch*SMP_W +: SMP_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= '0;
    else        corr_q <= corr_d;
  end

  assign corr_o = corr_q;

  // R1: a corrected value never exceeds the raw sample it came from
  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    corr_q[SMP_W-1:0] <= $past(raw_i[SMP_W-1:0]));

  // R1: a pedestal at or above the raw value clamps to zero
  a_r1_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_i[SMP_W-1:0]) <= $past(ped_i[SMP_W-1:0])) |-> (corr_q[SMP_W-1:0] == '0));
endmodule

// File: rtl/l0wt_win_sum.sv
`timescale 1ns/1ps
module l0wt_win_sum #(
  parameter int unsigned COLS  = 14,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned SMP_W = 12,
  parameter int unsigned WIN_W = 14
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic [COLS*ROWS*SMP_W-1:0]                  corr_i,
  output logic [(COLS-1)*(ROWS-1)*WIN_W-1:0]          win_o
);
  localparam int unsigned WCOLS = COLS - 1;
  localparam int unsigned WROWS = ROWS - 1;
  localparam int unsigned NWIN  = WCOLS * WROWS;

  logic [NWIN*WIN_W-1:0] win_d, win_q;

  always_comb begin
    for (int r = 0; r < WROWS; r++) begin
      for (int c = 0; c < WCOLS; c++) begin
        win_d[(r*WCOLS+c)*WIN_W +: WIN_W] =
            WIN_W'(corr_i[(r*COLS+c)*SMP_W +: SMP_W])
          + WIN_W'(corr_i[(r*COLS+c+1)*SMP_W +: SMP_W])
          + WIN_W'(corr_i[((r+1)*COLS+c)*SMP_W +: SMP_W])
          + WIN_W'(corr_i[((r+1)*COLS+c+1)*SMP_W +: SMP_W]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/l0wt_time_acc.sv
`timescale 1ns/1ps
module l0wt_time_acc #(
  parameter int unsigned NWIN   = 91,
  parameter int unsigned WIN_W  = 14,
  parameter int unsigned ACC_W  = 17,
  parameter int unsigned TDEPTH = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NWIN*WIN_W-1:0] win_i,
  output logic [NWIN*ACC_W-1:0] acc_o
);
  localparam int unsigned MAX_ACC = TDEPTH * 4 * ((2 ** (WIN_W - 2)) - 1);

  for (genvar gw = 0; gw < NWIN; gw++) begin : g_win
    logic [WIN_W-1:0] hist_q [TDEPTH];
    logic [WIN_W-1:0] hist_d [TDEPTH];
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [WIN_W-1:0] cur;

    assign cur = win_i[gw*WIN_W +: WIN_W];

    always_comb begin
      hist_d[0] = cur;
      for (int k = 1; k < TDEPTH; k++) hist_d[k] = hist_q[k-1];
      acc_d = acc_q + ACC_W'(cur) - ACC_W'(hist_q[TDEPTH-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= '{default: '0};
        acc_q  <= '0;
      end else begin
        hist_q <= hist_d;
        acc_q  <= acc_d;
      end
    end

    assign acc_o[gw*ACC_W +: ACC_W] = acc_q;
  end

  // R3: the running total never leaves the range of five full windows
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[ACC_W-1:0] <= ACC_W'(MAX_ACC));
endmodule

// File: rtl/l0_window_trigger.sv
`timescale 1ns/1ps
module l0_window_trigger
  import l0wt_pkg::*;
#(
  parameter int unsigned COLS   = 14,
  parameter int unsigned ROWS   = 8,
  parameter int unsigned SMP_W  = 12,
  parameter int unsigned TDEPTH = 5,
  parameter int unsigned DATA_W = SMP_W + 2 + $clog2(TDEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [COLS*ROWS*SMP_W-1:0]  samp_i,
  input  logic                        reg_wr_i,
  input  logic                        reg_rd_i,
  input  logic [REG_AW-1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]           reg_wdata_i,
  output logic [DATA_W-1:0]           reg_rdata_o,
  output logic                        l0_o
);
  localparam int unsigned NCH    = COLS * ROWS;
  localparam int unsigned NWIN   = (COLS - 1) * (ROWS - 1);
  localparam int unsigned WIN_W  = SMP_W + 2;
  localparam int unsigned ACC_W  = sum_width(WIN_W, TDEPTH);
  localparam int unsigned FILL   = TDEPTH + 2;
  localparam int unsigned FILL_W = $clog2(FILL + 1);
  localparam int unsigned PTR_W  = $clog2(NWIN);
  localparam int unsigned CHI_W  = $clog2(NCH);

  // reset: asserted at once, released on the second clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // pedestal registers
  logic [SMP_W-1:0]     ped_q [NCH];
  logic [NCH-1:0]       ped_we;
  logic [NCH*SMP_W-1:0] ped_bus;

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      ped_we[ch] = reg_wr_i && (reg_addr_i == REG_AW'(ch));
      ped_bus[ch*SMP_W +: SMP_W] = ped_q[ch];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int ch = 0; ch < NCH; ch++) ped_q[ch] <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++)
        if (ped_we[ch]) ped_q[ch] <= reg_wdata_i[SMP_W-1:0];
    end
  end

  // datapath
  logic [NCH*SMP_W-1:0] corr_bus;
  logic [NWIN*WIN_W-1:0] win_bus;
  logic [NWIN*ACC_W-1:0] acc_bus;
  logic [ACC_W-1:0]      acc_w [NWIN];

  l0wt_ped_sub #(.NCH(NCH), .SMP_W(SMP_W)) u_ped (
    .clk(clk), .rst_n(rst_sync_n), .raw_i(samp_i), .ped_i(ped_bus), .corr_o(corr_bus));

  l0wt_win_sum #(.COLS(COLS), .ROWS(ROWS), .SMP_W(SMP_W), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_sync_n), .corr_i(corr_bus), .win_o(win_bus));

  l0wt_time_acc #(.NWIN(NWIN), .WIN_W(WIN_W), .ACC_W(ACC_W), .TDEPTH(TDEPTH)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .win_i(win_bus), .acc_o(acc_bus));

  for (genvar gw = 0; gw < NWIN; gw++) begin : g_unpack
    assign acc_w[gw] = acc_bus[gw*ACC_W +: ACC_W];
  end

  // control state
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [ACC_W-1:0]  thr_q, thr_d;
  logic              en_q, en_d;
  logic              full_q, full_d;
  logic [PTR_W-1:0]  rdptr_q, rdptr_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              l0_q, l0_d;
  logic [ACC_W-1:0]  buf_q [NWIN];
  logic              hit, acc_vld, cap, buf_rd, rd_last;

  always_comb begin
    hit = 1'b0;
    for (int w = 0; w < NWIN; w++)
      if (acc_w[w] > thr_q) hit = 1'b1;
    acc_vld = (fill_q == FILL_W'(FILL));
    l0_d    = en_q & acc_vld & hit;
    cap     = l0_d & ~full_q;
    buf_rd  = reg_rd_i && (reg_addr_i == ADR_READOUT);
    rd_last = buf_rd && full_q && (rdptr_q == PTR_W'(NWIN - 1));
    fill_d  = acc_vld ? fill_q : fill_q + 1'b1;

    thr_d = thr_q;
    en_d  = en_q;
    if (reg_wr_i && (reg_addr_i == ADR_THRESH)) thr_d = reg_wdata_i[ACC_W-1:0];
    if (reg_wr_i && (reg_addr_i == ADR_CTRL))   en_d  = reg_wdata_i[0];

    full_d = full_q;
    if (cap)          full_d = 1'b1;
    else if (rd_last) full_d = 1'b0;

    rdptr_d = rdptr_q;
    if (buf_rd && full_q) rdptr_d = rd_last ? '0 : rdptr_q + 1'b1;

    rdata_d = rdata_q;
    if (reg_rd_i) begin
      rdata_d = '0;
      if (reg_addr_i < REG_AW'(NCH)) begin
        rdata_d[SMP_W-1:0] = ped_q[reg_addr_i[CHI_W-1:0]];
      end else begin
        case (reg_addr_i)
          ADR_THRESH:  rdata_d[ACC_W-1:0] = thr_q;
          ADR_CTRL:    rdata_d[0] = en_q;
          ADR_STATUS:  rdata_d[0] = full_q;
          ADR_READOUT: if (full_q) rdata_d[ACC_W-1:0] = buf_q[rdptr_q];
          default:     rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fill_q  <= '0;
      thr_q   <= '0;
      en_q    <= 1'b0;
      full_q  <= 1'b0;
      rdptr_q <= '0;
      rdata_q <= '0;
      l0_q    <= 1'b0;
    end else begin
      fill_q  <= fill_d;
      thr_q   <= thr_d;
      en_q    <= en_d;
      full_q  <= full_d;
      rdptr_q <= rdptr_d;
      rdata_q <= rdata_d;
      l0_q    <= l0_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int w = 0; w < NWIN; w++) buf_q[w] <= '0;
    end else if (cap) begin
      for (int w = 0; w < NWIN; w++) buf_q[w] <= acc_w[w];
    end
  end

  assign l0_o        = l0_q;
  assign reg_rdata_o = rdata_q;

  // R7: a trigger needs the enable that was set in the cycle before it
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    l0_q |-> $past(en_q));

  // R6: no trigger before the running sums hold five full sample sets
  a_r6_fill_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    l0_q |-> $past(fill_q == FILL_W'(FILL)));

  // R9: stored sums stay frozen while the buffer is held full
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (full_q && $past(full_q)) |-> $stable(buf_q[0]));

  // R10: reading the last word empties the buffer
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rd_last) |-> !full_q);
endmodule

// File: tb/l0_window_trigger_tb_top.sv
`timescale 1ns/1ps
module l0_window_trigger_tb_top;
  localparam int COLS = 14;
  localparam int ROWS = 8;
  localparam int NCH  = COLS * ROWS;
  localparam int WC   = COLS - 1;
  localparam int WR   = ROWS - 1;
  localparam int NWIN = WC * WR;
  localparam int DW   = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*12-1:0] samp_i;
  logic              reg_wr_i, reg_rd_i;
  logic [7:0]        reg_addr_i;
  logic [DW-1:0]     reg_wdata_i;
  logic [DW-1:0]     reg_rdata_o;
  logic              l0_o;

  always #5 clk = ~clk;

  l0_window_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .samp_i(samp_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .l0_o(l0_o));

  // stimulus and behavioural model state
  int smp [NCH];
  bit b_wr, b_rd;
  int b_addr, b_wdata;
  int mped [NCH];
  int mthr, men, mfull, mptr;
  int mcap [NWIN];
  int whist [8][NWIN];
  int e;
  bit exp_l0, exp_rdv;
  int exp_rd;
  int n_checks, n_fail;
  string tag;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic rnd(output int v, input int maxv);
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    v = int'(seed % (maxv + 1));
  endtask

  task automatic model_step();
    int cor [NCH];
    int t [NWIN];
    bit fire;
    bit full_old;
    for (int ch = 0; ch < NCH; ch++) cor[ch] = (smp[ch] > mped[ch]) ? smp[ch] - mped[ch] : 0;
    for (int r = 0; r < WR; r++)
      for (int c = 0; c < WC; c++)
        whist[e % 8][r*WC+c] = cor[r*COLS+c] + cor[r*COLS+c+1] + cor[(r+1)*COLS+c] + cor[(r+1)*COLS+c+1];
    fire = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      t[w] = 0;
      if (e >= 7) for (int k = 0; k < 5; k++) t[w] += whist[(e-3-k) % 8][w];
      if (e >= 7 && men != 0 && t[w] > mthr) fire = 1'b1;
    end
    exp_l0 = fire;
    full_old = (mfull != 0);
    exp_rdv = b_rd;
    exp_rd = 0;
    if (b_rd) begin
      if (b_addr < NCH)        exp_rd = mped[b_addr];
      else if (b_addr == 'h70) exp_rd = mthr;
      else if (b_addr == 'h71) exp_rd = men;
      else if (b_addr == 'h72) exp_rd = mfull;
      else if (b_addr == 'h73) exp_rd = full_old ? mcap[mptr] : 0;
    end
    if (fire && !full_old) begin
      for (int w = 0; w < NWIN; w++) mcap[w] = t[w];
      mfull = 1;
    end
    if (b_rd && b_addr == 'h73 && full_old) begin
      if (mptr == NWIN - 1) begin mptr = 0; mfull = 0; end
      else mptr++;
    end
    if (b_wr) begin
      if (b_addr < NCH)        mped[b_addr] = b_wdata & 'hfff;
      else if (b_addr == 'h70) mthr = b_wdata & 'h1ffff;
      else if (b_addr == 'h71) men = b_wdata & 1;
    end
    e++;
  endtask

  task automatic tick();
    for (int ch = 0; ch < NCH; ch++) samp_i[ch*12 +: 12] = 12'(smp[ch]);
    reg_wr_i    = b_wr;
    reg_rd_i    = b_rd;
    reg_addr_i  = 8'(b_addr);
    reg_wdata_i = DW'(b_wdata);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(l0_o == exp_l0, "l0_o", int'(l0_o), int'(exp_l0));
    if (exp_rdv) check(int'(reg_rdata_o) == exp_rd, "reg_rdata_o", int'(reg_rdata_o), exp_rd);
    b_wr = 1'b0;
    b_rd = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    b_wr = 1'b1; b_addr = a; b_wdata = d; tick();
  endtask

  task automatic rd(input int a);
    b_rd = 1'b1; b_addr = a; tick();
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic clear_smp();
    for (int ch = 0; ch < NCH; ch++) smp[ch] = 0;
  endtask

  task automatic rand_fill(input int maxv);
    for (int ch = 0; ch < NCH; ch++) rnd(smp[ch], maxv);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    b_wr = 1'b0; b_rd = 1'b0; b_addr = 0; b_wdata = 0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    clear_smp();
    samp_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) mped[ch] = 0;
    for (int w = 0; w < NWIN; w++) mcap[w] = 0;
    for (int s = 0; s < 8; s++) for (int w = 0; w < NWIN; w++) whist[s][w] = 0;
    mthr = 0; men = 0; mfull = 0; mptr = 0; e = 0;
    tag = "R11";
    check(l0_o == 1'b0, "l0_o after reset", int'(l0_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail = 0;

    // R11: reset values and empty-buffer read
    do_reset();
    rd('h70); rd('h71); rd('h72); rd('h73); rd(5); rd('h9a);
    idle(4);

    // R6: hot input from the first data edge; no trigger before the sums are full
    do_reset();
    tag = "R6";
    for (int ch = 0; ch < NCH; ch++) smp[ch] = 500;
    wr('h71, 1);
    idle(12);

    // R1: pedestal clamp and read-back
    do_reset();
    tag = "R1";
    wr(0, 200);
    wr('h71, 1);
    smp[0] = 150;
    idle(12);
    rd(0);
    smp[0] = 260;
    idle(10);

    // R2: single hot channel at row 3, column 5 lands in four windows
    do_reset();
    tag = "R2";
    wr('h71, 1);
    smp[3*COLS+5] = 1000;
    idle(10);
    rd('h72);
    for (int i = 0; i < NWIN; i++) rd('h73);
    rd('h72);

    // R3, R5: one-bunch pulse shows for exactly five clocks, three edges later
    do_reset();
    tag = "R3,R5";
    wr('h70, 999);
    wr('h71, 1);
    idle(8);
    smp[3*COLS+5] = 1000;
    tick();
    clear_smp();
    idle(12);

    // R4: equal to threshold does not fire, one below does
    do_reset();
    tag = "R4";
    wr('h70, 500);
    wr('h71, 1);
    smp[NCH-1] = 100;
    idle(14);
    wr('h70, 499);
    idle(8);

    // R7: enable cleared forces the output low
    tag = "R7";
    wr('h71, 0);
    idle(8);

    // R8, R9, R10: capture, hold while full, ordered drain
    do_reset();
    tag = "R9";
    wr('h70, 2000);
    wr('h71, 1);
    for (int i = 0; i < 40; i++) begin rand_fill(150); tick(); end
    tag = "R8";
    rand_fill(150);
    rd('h72);
    tag = "R10";
    for (int i = 0; i < NWIN; i++) begin rand_fill(150); rd('h73); end
    rand_fill(150);
    rd('h72);
    for (int i = 0; i < NWIN; i++) begin rand_fill(150); rd('h73); end

    // R4: random traffic with mixed pedestals
    tag = "R4";
    for (int i = 0; i < 8; i++) begin
      int a;
      int v;
      rnd(a, NCH - 1);
      rnd(v, 120);
      rand_fill(150);
      wr(a, v);
    end
    for (int i = 0; i < 150; i++) begin rand_fill(150); tick(); end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule